// File: doc/BRIEF.md
# Output Fault Check Sequencer

This controller runs one diagnostic pass against an eight-channel low-side switch that is controlled over a serial link. It sits on the host side. A start pulse captures a control byte, in which a 0 turns a channel on and a 1 turns it off. The sequencer shifts that byte out with enable held low and then raises enable, which makes the switch adopt the byte. It then waits a programmable settling interval so that inrush currents and the switch's own blanking time are over.

After the wait it shifts the same byte out a second time. During this second transfer it collects the diagnostic byte that the switch returns. Each returned bit is set against the bit that was programmed for that channel. A channel that was turned on but still reads high is flagged as shorted or overloaded. A channel that was turned off but reads low is flagged as open. The flags are held until the next pass, and a one-cycle done pulse marks the moment they are valid.

The state machine has seven states:

- **IDLE** waits for start.
- **WRITE1** runs the first transfer.
- **GAP** is a single cycle after enable has risen, in which the settle timer is armed.
- **SETTLE** counts the interval.
- **WRITE2** runs the readback transfer.
- **COMPARE** registers the flags.
- **DONE** pulses done.

It has these transitions:

- IDLE→WRITE1 on start.
- WRITE1→GAP when the serial engine finishes.
- GAP→SETTLE always.
- SETTLE→WRITE2 when the timer expires.
- WRITE2→COMPARE when the serial engine finishes.
- COMPARE→DONE always.
- DONE→IDLE always.

Top module: `fault_check_seq`

## Requirements
- R1: During and after reset, cs_o is 1, sclk_o is 0, busy_o and done_o are 0, and short_o and open_o are all zero.
- R2: A start_i pulse in IDLE captures ctrl_i and performs a first transfer: cs_o low, eight sclk_o pulses, sdo_o MSB (bit 7) first, then cs_o high, so the receiver latches exactly the captured byte.
- R3: After the settle interval, a second transfer sends the identical captured byte.
- R4: cs_o stays high for at least SETTLE_CYCLES clock cycles between the end of the first transfer and the start of the second.
- R5: sclk_o is 0 in the cycle before and the cycle of every rising or falling edge of cs_o.
- R6: When the returned byte equals the programmed byte, short_o and open_o are both zero.
- R7: short_o[i] is 1 exactly when channel i was programmed 0 (on) and returned 1 in the second transfer.
- R8: open_o[i] is 1 exactly when channel i was programmed 1 (off) and returned 0 in the second transfer.
- R9: done_o is high for one cycle with the flags valid, and in the next cycle both done_o and busy_o are low.
- R10: A start_i pulse while busy_o is 1 is ignored: the captured byte is unchanged and no extra transfer is started (exactly two cs_o falling edges per pass).
- R11: sdo_o changes only while sclk_o is low. The returned bit sdi_i is sampled at each rising edge of sclk_o, and the first bit received is channel 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to run one diagnostic pass |
| ctrl_i | input | N_CH | Control byte (bit i = channel i; 0 = on, 1 = off) |
| sdi_i | input | 1 | Serial diagnostic data from the switch |
| cs_o | output | 1 | Chip enable to the switch, low during a transfer |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial control data to the switch |
| busy_o | output | 1 | High whenever the sequencer is not in IDLE |
| done_o | output | 1 | One-cycle pulse when the fault flags are valid |
| short_o | output | N_CH | Per-channel short or overload flags |
| open_o | output | N_CH | Per-channel open-circuit flags |

## Verification
The assertions assume that sdi_i is stable from each falling edge of sclk_o until the following rising edge, and that SETTLE_CYCLES and CLK_DIV are at least 1. The bench's switch model meets the first assumption by updating its returned bit only half a system clock after it has seen sclk_o fall. Because CLK_DIV is 2, there are always at least two clock edges of settled data before the sequencer samples. Start pulses are also issued while a pass is running, once during the first transfer and once during the settle wait, to check that the captured byte and the transfer count are not disturbed.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE1,
        ST_GAP,
        ST_SETTLE,
        ST_WRITE2,
        ST_COMPARE,
        ST_DONE
    } fcs_state_e;

endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int LEN = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int TW = (LEN > 1) ? $clog2(LEN + 1) : 1;

    logic          run_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load_i) begin
            run_q <= 1'b1;
            cnt_q <= TW'(LEN - 1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/fcs_serial.sv
module fcs_serial #(
    parameter int NBITS    = 8,
    parameter int HALF_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NBITS-1:0] data_i,
    input  logic             sdi_i,
    output logic             cs_o,
    output logic             sclk_o,
    output logic             sdo_o,
    output logic             fin_o,
    output logic [NBITS-1:0] rx_o
);
    // half-periods: lead-in low, then high/low per bit, last low is the tail
    localparam int NHALF = 2 * NBITS + 1;
    localparam int HW    = $clog2(NHALF + 1);
    localparam int CW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic             active_q;
    logic [CW-1:0]    cnt_q;
    logic [HW-1:0]    half_q;
    logic [NBITS-1:0] tx_q;
    logic             half_end;

    assign half_end = (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cs_o     <= 1'b1;
            sclk_o   <= 1'b0;
            cnt_q    <= '0;
            half_q   <= '0;
            tx_q     <= '0;
            rx_o     <= '0;
            fin_o    <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (!active_q) begin
                if (go_i) begin
                    active_q <= 1'b1;
                    cs_o     <= 1'b0;
                    cnt_q    <= '0;
                    half_q   <= '0;
                    tx_q     <= data_i;
                end
            end else if (!half_end) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q  <= '0;
                half_q <= half_q + 1'b1;
                if (half_q == HW'(NHALF - 1)) begin
                    cs_o     <= 1'b1;
                    active_q <= 1'b0;
                    fin_o    <= 1'b1;
                end else if (!half_q[0]) begin
                    sclk_o <= 1'b1;
                    rx_o   <= {rx_o[NBITS-2:0], sdi_i};
                end else begin
                    sclk_o <= 1'b0;
                    tx_q   <= {tx_q[NBITS-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo_o = tx_q[NBITS-1];

    assert_sdo_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    assert_sclk_low_at_cs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_o) || $fell(cs_o)) |-> (!sclk_o && !$past(sclk_o)));

endmodule

// File: rtl/fault_check_seq.sv
module fault_check_seq
    import fcs_pkg::*;
#(
    parameter int N_CH          = 8,
    parameter int CLK_DIV       = 2,
    parameter int SETTLE_CYCLES = 8000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [N_CH-1:0] ctrl_i,
    input  logic            sdi_i,
    output logic            cs_o,
    output logic            sclk_o,
    output logic            sdo_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [N_CH-1:0] short_o,
    output logic [N_CH-1:0] open_o
);
    fcs_state_e      state_q, state_d;
    logic [N_CH-1:0] tx_q;
    logic [N_CH-1:0] rx_w;
    logic [N_CH-1:0] short_d, open_d;
    logic [N_CH-1:0] shift_data;
    logic            go, load, fin, expire;

    fcs_serial #(.NBITS(N_CH), .HALF_CYC(CLK_DIV)) u_serial (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .data_i (shift_data),
        .sdi_i  (sdi_i),
        .cs_o   (cs_o),
        .sclk_o (sclk_o),
        .sdo_o  (sdo_o),
        .fin_o  (fin),
        .rx_o   (rx_w)
    );

    fcs_timer #(.LEN(SETTLE_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .expire_o (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_WRITE1;
            ST_WRITE1:  if (fin) state_d = ST_GAP;
            ST_GAP:     state_d = ST_SETTLE;
            ST_SETTLE:  if (expire) state_d = ST_WRITE2;
            ST_WRITE2:  if (fin) state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and strobes
    always_comb begin
        go         = 1'b0;
        load       = 1'b0;
        shift_data = tx_q;
        unique case (state_q)
            ST_IDLE: begin
                go         = start_i;
                shift_data = ctrl_i;
            end
            ST_GAP:    load = 1'b1;
            ST_SETTLE: go = expire;
            default:   ;
        endcase
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_DONE);
    end

    // per-channel mismatch decode
    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
        assign short_d[g] = ~tx_q[g] &  rx_w[g];
        assign open_d[g]  =  tx_q[g] & ~rx_w[g];
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            short_o <= '0;
            open_o  <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) tx_q <= ctrl_i;
            if (state_q == ST_COMPARE) begin
                short_o <= short_d;
                open_o  <= open_d;
            end
        end
    end

    // cycles with enable high, used by the settle-window check
    logic [31:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hi_cnt_q <= '0;
        else if (!cs_o)                   hi_cnt_q <= '0;
        else if (hi_cnt_q != '1)          hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_settle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_o) && state_q == ST_WRITE2) |-> (hi_cnt_q >= 32'(SETTLE_CYCLES)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(tx_q));

    assert_flags_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && !$past(done_o)) |-> ($stable(short_o) && $stable(open_o)));

endmodule

// File: tb/fault_check_seq_tb.sv
module fault_check_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int DIV        = 2;
    localparam int SETTLE     = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [N-1:0] ctrl_i = '0;
    logic         sdi_i;
    logic         cs_o, sclk_o, sdo_o, busy_o, done_o;
    logic [N-1:0] short_o, open_o;

    fault_check_seq #(.N_CH(N), .CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i), .sdi_i(sdi_i),
        .cs_o(cs_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
        .short_o(short_o), .open_o(open_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // switch model, sampled away from the active edge
    logic [N-1:0] f_short = '0, f_open = '0;
    logic [N-1:0] dev_in = '0, dev_latch = '0, prev_latch = '0, dev_out = '0;
    int idx = 0, falls = 0, hi_cnt = 0, gap_at_fall = 0, bad_cs = 0, bad_sdo = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;

    function automatic logic [N-1:0] diag(input logic [N-1:0] lat);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (f_short[i] && !lat[i])     r[i] = 1'b1;
            else if (f_open[i] && lat[i])  r[i] = 1'b0;
            else                           r[i] = lat[i];
        end
        return r;
    endfunction

    assign sdi_i = (idx < N) ? dev_out[N-1-idx] : 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_o) begin
                falls++;
                gap_at_fall = hi_cnt;
                if (sclk_o || p_sclk) bad_cs++;
                dev_out = diag(dev_latch);
                idx = 0;
            end
            if (!p_cs && cs_o) begin
                if (sclk_o || p_sclk) bad_cs++;
                prev_latch = dev_latch;
                dev_latch  = dev_in;
            end
            if (!cs_o && sclk_o && !p_sclk) dev_in = {dev_in[N-2:0], sdo_o};
            if (!cs_o && !sclk_o && p_sclk) idx++;
            if (sclk_o && p_sclk && sdo_o !== p_sdo) bad_sdo++;
            hi_cnt = cs_o ? hi_cnt + 1 : 0;
        end
        p_cs = cs_o; p_sclk = sclk_o; p_sdo = sdo_o;
    end

    // scoreboard
    typedef struct {
        logic [N-1:0] b;
        logic [N-1:0] es;
        logic [N-1:0] eo;
        int           base;
    } exp_t;
    exp_t q[$];
    bit   chk_after = 1'b0;

    always @(negedge clk) begin
        if (chk_after) begin
            chk_after = 1'b0;
            chk("R9 done and busy low after pulse", {30'd0, done_o, busy_o}, 32'd0);
        end
        if (rst_n && done_o) begin
            if (q.size() == 0) begin
                chk("R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R2 first write latched", 32'(prev_latch), 32'(e.b));
                chk("R3 second write latched", 32'(dev_latch), 32'(e.b));
                chk("R4 settle window", 32'(gap_at_fall >= SETTLE), 32'd1);
                chk("R10 two transfers per pass", 32'(falls - e.base), 32'd2);
                chk("R7 short flags", 32'(short_o), 32'(e.es));
                chk("R8 open flags", 32'(open_o), 32'(e.eo));
                if (e.es == '0 && e.eo == '0)
                    chk("R6 no fault on match", {16'd0, short_o, open_o}, 32'd0);
            end
            chk_after = 1'b1;
        end
    end

    task automatic run_check(input logic [N-1:0] b, input logic [N-1:0] sm,
                             input logic [N-1:0] om, input bit poke);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        f_short = sm;
        f_open  = om;
        e.b = b; e.es = ~b & sm; e.eo = b & om; e.base = falls;
        q.push_back(e);
        ctrl_i  = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            ctrl_i = ~b; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs high in reset", 32'(cs_o), 32'd1);
        chk("R1 sclk low in reset", 32'(sclk_o), 32'd0);
        chk("R1 busy/done low in reset", {30'd0, busy_o, done_o}, 32'd0);
        chk("R1 flags clear in reset", {16'd0, short_o, open_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {29'd0, cs_o, sclk_o, busy_o}, 32'd4);

        run_check(8'hA5, 8'h00, 8'h00, 1'b0);
        run_check(8'h00, 8'h00, 8'h00, 1'b0);
        run_check(8'hFF, 8'h00, 8'h00, 1'b0);
        run_check(8'h0F, 8'hF0, 8'h00, 1'b0);
        run_check(8'h0F, 8'h00, 8'h0F, 1'b1);
        run_check(8'h3C, 8'hFF, 8'hFF, 1'b0);
        run_check(8'h81, 8'h01, 8'h80, 1'b1);
        run_check(8'h5A, 8'h00, 8'h00, 1'b1);

        chk("R5 sclk low at cs edges", 32'(bad_cs), 32'd0);
        chk("R11 sdo stable while sclk high", 32'(bad_sdo), 32'd0);
        chk("R9 every pass completed", 32'(q.size()), 32'd0);
        finish_run();
    end
endmodule